// File: doc/BRIEF.md
# Iterative MD5 Block Compression Engine

This engine applies the MD5 compression function to a single 512-bit message block and returns the updated 128-bit chaining value. It performs one generic step per clock, so a block takes 64 clocks. The four auxiliary functions share one datapath through a multiplexer, and the left rotate takes a variable amount. The additive constants, the rotate schedule and the order in which message words are read are all generated inside the engine.

The message block is held outside the engine. Each cycle the engine drives a 4-bit word address, and the surrounding buffer must return the addressed 32-bit word combinationally in the same cycle.

To hash a block, the user pulses `start` while the engine is idle. If `init` is high, the working registers and a saved copy are loaded from the fixed initial vector; if it is low, they are loaded from `chain_in`. When all 64 steps are done, the engine adds the saved copy to the working registers word by word, registers the sum on `chain_out` and raises `done` for one cycle. A multi-block message is hashed by feeding each result back on `chain_in` with `init` low. Padding and message buffering belong to the caller.

Top module: `md5_iter_core`

## Requirements
- R1: After reset, `busy` and `done` are low and `chain_out` is all zeros.
- R2: A start with `init` high loads the words A=0x67452301, B=0xEFCDAB89, C=0x98BADCFE and D=0x10325476, and `chain_in` has no effect. The padded empty message (word 0 = 0x00000080, all other words 0) then gives `chain_out` = 0xd98c1dd4_04b2008f_980980e9_7e42f8ec.
- R3: A start with `init` low loads A, B, C and D from `chain_in` bits [127:96], [95:64], [63:32] and [31:0]. A later change on `chain_in` does not affect the block in progress.
- R4: In step j (0..15) of rounds 1 to 4, `msg_word_idx` is j, (1+5j) mod 16, (5+3j) mod 16 and 7j mod 16 respectively. `msg_word` is sampled in that same cycle.
- R5: Each step computes B + rotl(A + f(B,C,D) + X + T, s) into B, and moves the old D into A, the old B into C and the old C into D. Here f is F, G, H, I in rounds 1 to 4, T is floor(2^32·|sin(n)|) for step n = 1..64, and s cycles through 7/12/17/22, 5/9/14/20, 4/11/16/23 and 6/10/15/21 by round. All additions are modulo 2^32.
- R6: If `start` is sampled at clock edge E, `busy` is high from E up to edge E+64. At E+64, `done` pulses high for exactly one cycle together with the new `chain_out`.
- R7: A `start` while `busy` is high is ignored, and the block in progress completes unchanged.
- R8: `chain_out` changes only at a completion and holds its value between completions.
- R9: Feeding `chain_out` back on `chain_in` with `init` low gives the chaining value of a two-block message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the engine |
| start | input | 1 | Begin a block; honoured only while idle |
| init | input | 1 | At start: 1 selects the fixed initial vector, 0 selects `chain_in` |
| chain_in | input | 128 | Previous chaining value, A in the top word |
| msg_word_idx | output | 4 | Index of the message word needed in the current step |
| msg_word | input | 32 | Addressed message word, returned in the same cycle |
| busy | output | 1 | A block is being processed |
| done | output | 1 | One-cycle completion pulse |
| chain_out | output | 128 | Updated chaining value, A in the top word |

## Verification
The assertions check on every cycle how the word index advances within each round, that `done` lasts one cycle and coincides with the end of `busy`, that a start during a run does not disturb the step sequence, and that `chain_out` stays put outside completions. Whether the additive constants, the rotate amounts, the round functions and the final addition are correct can only be shown by the bench's scenarios. These compare whole chaining values against an arithmetic model, across swept blocks and chaining values, against the known empty-message digest and against a two-block chain.

// File: rtl/md5_pkg.sv
package md5_pkg;
  localparam int WORD_W  = 32;
  localparam int STATE_W = 4 * WORD_W;
  localparam int STEPS   = 64;
  localparam int STEP_W  = $clog2(STEPS);
  localparam int IDX_W   = 4;

  localparam logic [STATE_W-1:0] IV_WORDS =
    {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476};

  typedef logic [WORD_W-1:0] word_t;

  // Round function, selected by the round number (0..3)
  function automatic word_t mix_fn(input logic [1:0] rnd, input word_t x, input word_t y, input word_t z);
    case (rnd)
      2'd0:    return (x & y) | (~x & z);
      2'd1:    return (x & z) | (y & ~z);
      2'd2:    return x ^ y ^ z;
      default: return y ^ (x | ~z);
    endcase
  endfunction

  // Message word index for a step
  function automatic logic [IDX_W-1:0] word_sel(input logic [STEP_W-1:0] st);
    logic [IDX_W-1:0] j;
    j = st[IDX_W-1:0];
    case (st[5:4])
      2'd0:    return j;
      2'd1:    return 4'd1 + {j[1:0], 2'b00} + j;
      2'd2:    return 4'd5 + {j[2:0], 1'b0} + j;
      default: return {j[0], 3'b000} - j;
    endcase
  endfunction

  // Rotate amount for a step
  function automatic logic [4:0] rot_amt(input logic [STEP_W-1:0] st);
    case ({st[5:4], st[1:0]})
      4'h0: return 5'd7;   4'h1: return 5'd12;  4'h2: return 5'd17;  4'h3: return 5'd22;
      4'h4: return 5'd5;   4'h5: return 5'd9;   4'h6: return 5'd14;  4'h7: return 5'd20;
      4'h8: return 5'd4;   4'h9: return 5'd11;  4'hA: return 5'd16;  4'hB: return 5'd23;
      4'hC: return 5'd6;   4'hD: return 5'd10;  4'hE: return 5'd15;  default: return 5'd21;
    endcase
  endfunction

  function automatic word_t rotl(input word_t x, input logic [4:0] s);
    return (x << s) | (x >> (6'd32 - {1'b0, s}));
  endfunction

  // Additive constant for a step: floor(2^32*|sin(step+1)|)
  function automatic word_t sine_k(input logic [STEP_W-1:0] st);
    case (st)
      6'd0:  return 32'hd76aa478; 6'd1:  return 32'he8c7b756; 6'd2:  return 32'h242070db; 6'd3:  return 32'hc1bdceee;
      6'd4:  return 32'hf57c0faf; 6'd5:  return 32'h4787c62a; 6'd6:  return 32'ha8304613; 6'd7:  return 32'hfd469501;
      6'd8:  return 32'h698098d8; 6'd9:  return 32'h8b44f7af; 6'd10: return 32'hffff5bb1; 6'd11: return 32'h895cd7be;
      6'd12: return 32'h6b901122; 6'd13: return 32'hfd987193; 6'd14: return 32'ha679438e; 6'd15: return 32'h49b40821;
      6'd16: return 32'hf61e2562; 6'd17: return 32'hc040b340; 6'd18: return 32'h265e5a51; 6'd19: return 32'he9b6c7aa;
      6'd20: return 32'hd62f105d; 6'd21: return 32'h02441453; 6'd22: return 32'hd8a1e681; 6'd23: return 32'he7d3fbc8;
      6'd24: return 32'h21e1cde6; 6'd25: return 32'hc33707d6; 6'd26: return 32'hf4d50d87; 6'd27: return 32'h455a14ed;
      6'd28: return 32'ha9e3e905; 6'd29: return 32'hfcefa3f8; 6'd30: return 32'h676f02d9; 6'd31: return 32'h8d2a4c8a;
      6'd32: return 32'hfffa3942; 6'd33: return 32'h8771f681; 6'd34: return 32'h6d9d6122; 6'd35: return 32'hfde5380c;
      6'd36: return 32'ha4beea44; 6'd37: return 32'h4bdecfa9; 6'd38: return 32'hf6bb4b60; 6'd39: return 32'hbebfbc70;
      6'd40: return 32'h289b7ec6; 6'd41: return 32'heaa127fa; 6'd42: return 32'hd4ef3085; 6'd43: return 32'h04881d05;
      6'd44: return 32'hd9d4d039; 6'd45: return 32'he6db99e5; 6'd46: return 32'h1fa27cf8; 6'd47: return 32'hc4ac5665;
      6'd48: return 32'hf4292244; 6'd49: return 32'h432aff97; 6'd50: return 32'hab9423a7; 6'd51: return 32'hfc93a039;
      6'd52: return 32'h655b59c3; 6'd53: return 32'h8f0ccc92; 6'd54: return 32'hffeff47d; 6'd55: return 32'h85845dd1;
      6'd56: return 32'h6fa87e4f; 6'd57: return 32'hfe2ce6e0; 6'd58: return 32'ha3014314; 6'd59: return 32'h4e0811a1;
      6'd60: return 32'hf7537e82; 6'd61: return 32'hbd3af235; 6'd62: return 32'h2ad7d2bb; default: return 32'heb86d391;
    endcase
  endfunction
endpackage

// File: rtl/md5_rst_sync.sv
module md5_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/md5_seq.sv
module md5_seq
  import md5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              load,
  output logic              advance,
  output logic              last,
  output logic [STEP_W-1:0] step,
  output logic              busy,
  output logic              done
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic              busy_q, busy_d, done_q, done_d;
  logic [STEP_W-1:0] step_q, step_d;

  always_comb begin
    load    = start & ~busy_q;
    advance = busy_q;
    last    = busy_q & (step_q == LAST_STEP);
    busy_d  = busy_q;
    step_d  = step_q;
    done_d  = last;
    if (load) begin
      busy_d = 1'b1;
      step_d = '0;
    end else if (advance) begin
      step_d = step_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign step = step_q;
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/md5_step_dp.sv
module md5_step_dp
  import md5_pkg::*;
(
  input  logic [STEP_W-1:0]  step,
  input  logic [STATE_W-1:0] work_in,
  input  logic [WORD_W-1:0]  msg_word,
  output logic [IDX_W-1:0]   word_idx,
  output logic [STATE_W-1:0] work_out
);
  word_t a, b, c, d, f, sum, rot;

  always_comb begin
    {a, b, c, d} = work_in;
    f        = mix_fn(step[5:4], b, c, d);
    sum      = a + f + msg_word + sine_k(step);
    rot      = rotl(sum, rot_amt(step));
    work_out = {d, b + rot, b, c};
    word_idx = word_sel(step);
  end
endmodule

// File: rtl/md5_iter_core.sv
module md5_iter_core
  import md5_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         init,
  input  logic [127:0] chain_in,
  output logic [3:0]   msg_word_idx,
  input  logic [31:0]  msg_word,
  output logic         busy,
  output logic         done,
  output logic [127:0] chain_out
);
  logic               rst_sync_n;
  logic               load, advance, last;
  logic [STEP_W-1:0]  step_cnt;
  logic [STATE_W-1:0] work_q, work_d, save_q, save_d, out_q, out_d;
  logic [STATE_W-1:0] step_res, load_val, final_sum;

  md5_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  md5_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .load(load), .advance(advance), .last(last),
    .step(step_cnt), .busy(busy), .done(done)
  );

  md5_step_dp u_dp (
    .step(step_cnt), .work_in(work_q), .msg_word(msg_word),
    .word_idx(msg_word_idx), .work_out(step_res)
  );

  // Word-wise feed-forward of the saved chaining value
  for (genvar w = 0; w < 4; w++) begin : g_ff
    assign final_sum[w*WORD_W +: WORD_W] =
      save_q[w*WORD_W +: WORD_W] + step_res[w*WORD_W +: WORD_W];
  end

  always_comb begin
    load_val = init ? IV_WORDS : chain_in;
    work_d   = work_q;
    save_d   = save_q;
    out_d    = out_q;
    if (load) begin
      work_d = load_val;
      save_d = load_val;
    end else if (advance) begin
      work_d = step_res;
    end
    if (last) out_d = final_sum;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      work_q <= '0;
      save_q <= '0;
      out_q  <= '0;
    end else begin
      if (load | advance) work_q <= work_d;
      if (load)           save_q <= save_d;
      if (last)           out_q  <= out_d;
    end
  end

  assign chain_out = out_q;
endmodule

// File: rtl/md5_iter_core_chk.sv
module md5_iter_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [5:0]   step_cnt,
  input logic [3:0]   msg_word_idx,
  input logic [127:0] chain_out
);
  function automatic logic [3:0] stride(input logic [1:0] rnd);
    case (rnd)
      2'd0: return 4'd1;
      2'd1: return 4'd5;
      2'd2: return 4'd3;
      default: return 4'd7;
    endcase
  endfunction

  // R4: within a round the word index advances by the round's stride
  a_r4_idx_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && step_cnt[5:4] == $past(step_cnt[5:4]))
      |-> msg_word_idx == $past(msg_word_idx) + stride(step_cnt[5:4]));

  // R6: done lasts exactly one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: busy ends exactly when done appears
  a_r6_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6: done is never raised while busy
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: start during a run leaves the step sequence undisturbed
  a_r7_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && step_cnt != 6'd63) |=> (busy && step_cnt == $past(step_cnt) + 6'd1));

  // R8: result holds outside completions
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(chain_out));
endmodule

bind md5_iter_core md5_iter_core_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .busy(busy), .done(done),
  .step_cnt(step_cnt), .msg_word_idx(msg_word_idx), .chain_out(chain_out)
);

// File: tb/sim_md5_iter_core.sv
`timescale 1ns/1ps
module sim_md5_iter_core;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, init;
  logic [127:0] chain_in;
  logic [3:0]   msg_word_idx;
  logic [31:0]  msg_word;
  logic         busy, done;
  logic [127:0] chain_out;

  logic [31:0] blk [16];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] seed = 32'h1234abcd;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign msg_word = blk[msg_word_idx];

  md5_iter_core u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .init(init), .chain_in(chain_in),
    .msg_word_idx(msg_word_idx), .msg_word(msg_word), .busy(busy), .done(done),
    .chain_out(chain_out)
  );

  function automatic logic [31:0] rnd32();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [31:0] tk(input int n);
    real r;
    longint unsigned v;
    r = $sin(real'(n));
    if (r < 0.0) r = -r;
    v = longint'($floor(r * 4294967296.0));
    return v[31:0];
  endfunction

  function automatic logic [3:0] exp_idx(input int i);
    int j;
    j = i % 16;
    case (i / 16)
      0: return 4'(j);
      1: return 4'((1 + 5 * j) % 16);
      2: return 4'((5 + 3 * j) % 16);
      default: return 4'((7 * j) % 16);
    endcase
  endfunction

  function automatic int exp_rot(input int i);
    int tbl [16] = '{7, 12, 17, 22, 5, 9, 14, 20, 4, 11, 16, 23, 6, 10, 15, 21};
    return tbl[(i / 16) * 4 + (i % 4)];
  endfunction

  function automatic logic [127:0] ref_block(input logic [127:0] cv);
    logic [31:0] a, b, c, d, f, t, r;
    int s;
    {a, b, c, d} = cv;
    for (int i = 0; i < 64; i++) begin
      case (i / 16)
        0: f = d ^ (b & (c ^ d));
        1: f = c ^ (d & (b ^ c));
        2: f = b ^ c ^ d;
        default: f = c ^ (b | ~d);
      endcase
      t = a + f + blk[exp_idx(i)] + tk(i + 1);
      s = exp_rot(i);
      r = (t << s) | (t >> (32 - s));
      a = d; d = c; c = b; b = b + r;
    end
    return {cv[127:96] + a, cv[95:64] + b, cv[63:32] + c, cv[31:0] + d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one block; optionally pulses start and scrambles chain_in mid-run.
  task automatic run_block(input logic ini, input logic [127:0] cin, input bit disturb,
                           input string req, output logic [127:0] res);
    logic [127:0] exp;
    bit idx_ok, busy_ok;
    exp = ref_block(ini ? 128'h67452301_efcdab89_98badcfe_10325476 : cin);
    idx_ok = 1; busy_ok = 1;
    @(negedge clk);
    init = ini; chain_in = cin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 64; k++) begin
      if (msg_word_idx !== exp_idx(k)) idx_ok = 0;
      if (busy !== 1'b1 || done !== 1'b0) busy_ok = 0;
      if (disturb && k == 10) begin
        start = 1'b1; init = ~ini; chain_in = ~cin;
      end
      if (disturb && k == 11) start = 1'b0;
      @(negedge clk);
    end
    check(idx_ok, "R4 word index sequence", 0, 0);
    check(busy_ok, "R6 busy during 64 steps", 0, 0);
    check(done === 1'b1 && busy === 1'b0, "R6 done at step 64", {done, busy}, 2'b10);
    check(chain_out === exp, req, chain_out, exp);
    res = chain_out;
    @(negedge clk);
    check(done === 1'b0, "R6 done one cycle", done, 0);
  endtask

  initial begin
    logic [127:0] res, res1, held;
    rst_n = 1'b0; start = 1'b0; init = 1'b0; chain_in = '0;
    for (int i = 0; i < 16; i++) blk[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(busy === 1'b0 && done === 1'b0 && chain_out === '0, "R1 reset state",
          {busy, done, chain_out}, 0);

    // R2: empty message with the fixed initial vector
    blk[0] = 32'h00000080;
    run_block(1'b1, '0, 0, "R2 empty digest", res);
    check(res === 128'hd98c1dd4_04b2008f_980980e9_7e42f8ec, "R2 known empty digest",
          res, 128'hd98c1dd4_04b2008f_980980e9_7e42f8ec);
    // R2: chain_in ignored when init is high
    run_block(1'b1, {rnd32(), rnd32(), rnd32(), rnd32()}, 0, "R2 init ignores chain_in", res);

    // R8: hold between completions
    held = chain_out;
    repeat (7) @(negedge clk);
    check(chain_out === held, "R8 output holds", chain_out, held);

    // R3/R5 sweep: single-bit blocks at every word and random chaining values
    for (int j = 0; j < 16; j++) begin
      for (int i = 0; i < 16; i++) blk[i] = '0;
      blk[j] = 32'h1 << ((j * 7) % 32);
      run_block(1'b0, {rnd32(), rnd32(), rnd32(), rnd32()}, 0, "R3 R5 single-bit block", res);
    end
    // R5 random blocks, extreme chaining values included
    for (int j = 0; j < 12; j++) begin
      for (int i = 0; i < 16; i++) blk[i] = rnd32();
      run_block(1'b0, (j == 0) ? '1 : (j == 1) ? '0 : {rnd32(), rnd32(), rnd32(), rnd32()},
                0, "R5 random block", res);
    end

    // R7: start and chain_in changes during a run have no effect (R3 as well)
    for (int i = 0; i < 16; i++) blk[i] = rnd32();
    run_block(1'b0, {rnd32(), rnd32(), rnd32(), rnd32()}, 1, "R7 start ignored while busy", res);
    run_block(1'b1, '0, 1, "R7 init block undisturbed", res);

    // R9: two-block chain
    for (int i = 0; i < 16; i++) blk[i] = rnd32();
    run_block(1'b1, '0, 0, "R9 first block", res1);
    for (int i = 0; i < 16; i++) blk[i] = rnd32();
    run_block(1'b0, res1, 0, "R9 chained second block", res);
    check(res === ref_block(res1), "R9 chain result", res, ref_block(res1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc == 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule